// File: doc/BRIEF.md
# Reconfiguration Status and Fallback Tracker

This block is the control side of a dual-image remote-upgrade controller. A state machine records which of two configuration images is being loaded, and whether that load is a first attempt or a fallback after the other image failed. A user watchdog counts down from a programmable 29-bit timeout once a load has finished. If the application does not kick the watchdog before the count runs out, the expiry is treated as a failure of the running image.

Every reconfiguration event latches a previous-state word. The word holds the highest-priority cause of the event and the state code that was in effect when it happened. Two readback words are provided. The current-state word shows the state code, the watchdog enable and the configured timeout. The previous-state word shows the last recorded event.

Flash access and bitstream loading are outside the block. They are represented by a pair of inputs, load done and load fail.

The states and their transitions are as follows:

- IDLE (0000) moves to LOAD0 (0010) on a start pulse with image select low, and to LOAD1 (0100) on a start pulse with image select high.
- A failure is a load-fail pulse or a watchdog expiry. On a failure, LOAD0 moves to REV1 (0011, image 1 loading after a revert) and LOAD1 moves to REV0 (0101, image 0 loading after a revert).
- A failure in REV1 or REV0 moves to ERR (1111). ERR is held until reset.

Top module: `recfg_tracker`

## Requirements
- R1: After reset the state code is 0000 (IDLE) and the previous-state word is all zero.
- R2: A start pulse in IDLE enters 0010 when image select is 0, and enters 0100 when image select is 1. A start pulse in any other state is ignored.
- R3: A failure moves state 0010 to 0011 and moves state 0100 to 0101.
- R4: A failure in 0011 or 0101 moves to 1111. State 1111 holds until reset.
- R5: The current-state word is {state[33:30], watchdog enable[29], timeout[28:0]}. The watchdog enable is active high.
- R6: The watchdog runs only while it is enabled and a load-done has been seen in the present state. With timeout T and no kick, suppose load-done is sampled at clock edge k. The state change then appears after edge k+T+1. Without a load-done, no expiry occurs.
- R7: A kick sampled at edge j reloads the count, so the expiry takes effect after edge j+T+1.
- R8: The previous-state word carries these fields. Bit 31 is the configuration-pin cause, bit 30 the CRC-error cause, bit 29 the status-pin cause and bit 28 the watchdog-expiry cause. Bits 25:22 hold the captured state. Bits 27:26 and 21:0 are zero.
- R9: When causes coincide, only the highest-numbered cause bit is set. A user-requested reconfiguration sets no cause bit but still captures the state code.
- R10: The previous-state word changes only on a cycle with an event, and holds its value otherwise.
- R11: A watchdog expiry is handled as a failure, giving the same transition as in R3 or R4. It also sets bit 28 and captures the state that was in effect before the transition.
- R12: With the watchdog enable low, no expiry occurs, however long the count would have run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted in IDLE |
| img_sel_i | input | 1 | Image chosen at start (0 or 1) |
| load_done_i | input | 1 | Image load completed |
| load_fail_i | input | 1 | Image load failed |
| ev_cfg_pin_i | input | 1 | Configuration-pin event (highest priority) |
| ev_crc_i | input | 1 | CRC-error event |
| ev_stat_i | input | 1 | Status-pin event |
| ev_user_i | input | 1 | User-requested reconfiguration |
| wd_kick_i | input | 1 | Watchdog kick |
| wd_en_i | input | 1 | Watchdog enable, active high |
| wd_timeout_i | input | 29 | Watchdog timeout count |
| cur_word_o | output | 34 | Current-state readback word |
| prev_word_o | output | 32 | Previous-state readback word |

## Verification
A watchdog expiry and an external cause event can fall in the same cycle. The expiry moves the state machine into a revert state, and at the same time the cause latch must choose a flag and capture a state code. The bench lets the watchdog count down to the exact cycle of expiry and pulses the CRC-error input on that same cycle. It then expects three results: only bit 30 set, the pre-revert state code captured, and the revert transition still taken. The stimulus table also tests coinciding external causes and user requests, with the state captured before a failure and after it.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
    localparam int ST_W    = 4;
    localparam int N_CAUSE = 4;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 4'b0000,
        ST_LOAD0 = 4'b0010,
        ST_REV1  = 4'b0011,
        ST_LOAD1 = 4'b0100,
        ST_REV0  = 4'b0101,
        ST_ERR   = 4'b1111
    } st_e;

    function automatic logic is_load_state(st_e s);
        return (s == ST_LOAD0) || (s == ST_LOAD1) || (s == ST_REV0) || (s == ST_REV1);
    endfunction
endpackage

// File: rtl/recfg_fsm.sv
module recfg_fsm
    import recfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic img_sel,
    input  logic load_done,
    input  logic load_fail,
    input  logic wd_expire,
    output st_e  state,
    output logic loaded
);
    st_e  state_q;
    st_e  nxt;
    logic fail;

    assign fail = load_fail || wd_expire;

    // next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) nxt = img_sel ? ST_LOAD1 : ST_LOAD0;
            ST_LOAD0: if (fail)  nxt = ST_REV1;
            ST_LOAD1: if (fail)  nxt = ST_REV0;
            ST_REV1:  if (fail)  nxt = ST_ERR;
            ST_REV0:  if (fail)  nxt = ST_ERR;
            ST_ERR:   nxt = ST_ERR;
            default:  nxt = ST_ERR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // output register: load-complete flag, cleared on every state change
    always_ff @(posedge clk) begin
        if (!rst_n)
            loaded <= 1'b0;
        else if (nxt != state_q)
            loaded <= 1'b0;
        else if (load_done && is_load_state(state_q))
            loaded <= 1'b1;
    end

    assign state = state_q;
endmodule

// File: rtl/recfg_wdog.sv
module recfg_wdog #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic [CNT_W-1:0] timeout,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // expiry fires in the cycle the running count sits at zero
    assign expire = run && !kick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || kick)
            cnt <= timeout;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/recfg_cause_latch.sv
module recfg_cause_latch #(
    parameter int NC  = 4,
    parameter int S_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NC-1:0]  causes,
    input  logic           user_req,
    input  logic [S_W-1:0] state,
    output logic [NC-1:0]  flags_q,
    output logic [S_W-1:0] state_q
);
    logic [NC-1:0] win;
    logic          any_evt;

    // fixed priority: the highest index wins
    always_comb begin
        win = '0;
        for (int i = 0; i < NC; i++) begin
            if (causes[i]) win = NC'(1) << i;
        end
    end

    assign any_evt = (|causes) || user_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            state_q <= '0;
        end else if (any_evt) begin
            flags_q <= win;
            state_q <= state;
        end
    end
endmodule

// File: rtl/recfg_tracker.sv
module recfg_tracker
    import recfg_pkg::*;
#(
    parameter int TMO_W = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  img_sel_i,
    input  logic                  load_done_i,
    input  logic                  load_fail_i,
    input  logic                  ev_cfg_pin_i,
    input  logic                  ev_crc_i,
    input  logic                  ev_stat_i,
    input  logic                  ev_user_i,
    input  logic                  wd_kick_i,
    input  logic                  wd_en_i,
    input  logic [TMO_W-1:0]      wd_timeout_i,
    output logic [ST_W+TMO_W:0]   cur_word_o,
    output logic [31:0]           prev_word_o
);
    localparam int LO_PAD = 32 - N_CAUSE - 2 - ST_W;

    st_e               state;
    logic              loaded;
    logic              wd_expire;
    logic [N_CAUSE-1:0] causes;
    logic [N_CAUSE-1:0] flags_q;
    logic [ST_W-1:0]   cap_state;

    recfg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .img_sel   (img_sel_i),
        .load_done (load_done_i),
        .load_fail (load_fail_i),
        .wd_expire (wd_expire),
        .state     (state),
        .loaded    (loaded)
    );

    recfg_wdog #(.CNT_W(TMO_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_en_i && loaded),
        .kick    (wd_kick_i),
        .timeout (wd_timeout_i),
        .expire  (wd_expire)
    );

    assign causes = {ev_cfg_pin_i, ev_crc_i, ev_stat_i, wd_expire};

    recfg_cause_latch #(.NC(N_CAUSE), .S_W(ST_W)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .causes   (causes),
        .user_req (ev_user_i),
        .state    (state),
        .flags_q  (flags_q),
        .state_q  (cap_state)
    );

    assign cur_word_o  = {state, wd_en_i, wd_timeout_i};
    assign prev_word_o = {flags_q, 2'b00, cap_state, {(LO_PAD - 2){1'b0}}, 2'b00};
endmodule

// File: rtl/recfg_tracker_chk.sv
module recfg_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        img_sel_i,
    input logic        load_fail_i,
    input logic        ev_cfg_pin_i,
    input logic        ev_crc_i,
    input logic        ev_stat_i,
    input logic        ev_user_i,
    input logic        wd_expire,
    input logic [33:0] cur_word_o,
    input logic [31:0] prev_word_o
);
    logic [3:0] st;
    logic       any_evt;
    assign st      = cur_word_o[33:30];
    assign any_evt = ev_cfg_pin_i || ev_crc_i || ev_stat_i || ev_user_i || wd_expire;

    assert_start_img0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 4'b0000 && start_i && !img_sel_i) |=> (cur_word_o[33:30] == 4'b0010));

    assert_start_img1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 4'b0000 && start_i && img_sel_i) |=> (cur_word_o[33:30] == 4'b0100));

    assert_revert_img0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 4'b0010 && load_fail_i) |=> (cur_word_o[33:30] == 4'b0011));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 4'b1111) |=> (cur_word_o[33:30] == 4'b1111));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_word_o[27:26] == 2'b00) && (prev_word_o[21:0] == 22'd0));

    assert_single_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prev_word_o[31:28]));

    assert_cfg_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cfg_pin_i |=> (prev_word_o[31:28] == 4'b1000));

    assert_prev_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> $stable(prev_word_o));

    assert_expire_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !wd_expire);
endmodule

bind recfg_tracker recfg_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .img_sel_i    (img_sel_i),
    .load_fail_i  (load_fail_i),
    .ev_cfg_pin_i (ev_cfg_pin_i),
    .ev_crc_i     (ev_crc_i),
    .ev_stat_i    (ev_stat_i),
    .ev_user_i    (ev_user_i),
    .wd_expire    (wd_expire),
    .cur_word_o   (cur_word_o),
    .prev_word_o  (prev_word_o)
);

// File: tb/test_recfg_tracker.sv
module test_recfg_tracker;
    localparam int T = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, img_sel_i = 0, load_done_i = 0, load_fail_i = 0;
    logic        ev_cfg_pin_i = 0, ev_crc_i = 0, ev_stat_i = 0, ev_user_i = 0;
    logic        wd_kick_i = 0, wd_en_i = 0;
    logic [28:0] wd_timeout_i = 29'(T);
    logic [33:0] cur_word_o;
    logic [31:0] prev_word_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    recfg_tracker i_recfg_tracker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_sel_i(img_sel_i),
        .load_done_i(load_done_i), .load_fail_i(load_fail_i),
        .ev_cfg_pin_i(ev_cfg_pin_i), .ev_crc_i(ev_crc_i), .ev_stat_i(ev_stat_i),
        .ev_user_i(ev_user_i), .wd_kick_i(wd_kick_i), .wd_en_i(wd_en_i),
        .wd_timeout_i(wd_timeout_i), .cur_word_o(cur_word_o), .prev_word_o(prev_word_o)
    );

    // {start, sel, done, fail, cfg, crc, stat, user, exp_state, exp_flags, exp_prev_state}
    localparam logic [19:0] VEC [9] = '{
        {8'b1000_0000, 4'b0010, 4'b0000, 4'b0000}, // R2 start image 0
        {8'b0000_0110, 4'b0010, 4'b0100, 4'b0010}, // R9 crc beats stat
        {8'b0001_0000, 4'b0011, 4'b0100, 4'b0010}, // R3 revert, R10 hold
        {8'b0000_0001, 4'b0011, 4'b0000, 4'b0011}, // R9 user request, no flag
        {8'b1100_0000, 4'b0011, 4'b0000, 4'b0011}, // R2 start ignored
        {8'b0000_1111, 4'b0011, 4'b1000, 4'b0011}, // R9 all causes, cfg wins
        {8'b0001_0000, 4'b1111, 4'b1000, 4'b0011}, // R4 fail in revert
        {8'b0000_0010, 4'b1111, 4'b0010, 4'b1111}, // R8 stat flag
        {8'b1000_0000, 4'b1111, 4'b0010, 4'b1111}  // R4 error sticky
    };

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic pulse_start(input logic sel);
        start_i = 1; img_sel_i = sel;
        step();
        start_i = 0; img_sel_i = 0;
    endtask

    task automatic pulse_done();
        load_done_i = 1;
        step();
        load_done_i = 0;
    endtask

    function automatic logic [3:0] st();
        return cur_word_o[33:30];
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wd_en_i = 1'b1;
        do_reset();
        // R1 reset state, R5 word layout
        check("R1", 34'(st()), 34'h0);
        check("R1", 34'(prev_word_o), 34'h0);
        check("R5", cur_word_o, {4'b0000, 1'b1, 29'(T)});
        wd_en_i = 1'b0;

        // table walk, watchdog disabled
        for (int i = 0; i < 9; i++) begin
            {start_i, img_sel_i, load_done_i, load_fail_i,
             ev_cfg_pin_i, ev_crc_i, ev_stat_i, ev_user_i} = VEC[i][19:12];
            step();
            {start_i, img_sel_i, load_done_i, load_fail_i,
             ev_cfg_pin_i, ev_crc_i, ev_stat_i, ev_user_i} = 8'h00;
            check("R2/R3/R4 state", 34'(st()), 34'(VEC[i][11:8]));
            check("R9/R10 flags", 34'(prev_word_o[31:28]), 34'(VEC[i][7:4]));
            check("R8 captured state", 34'(prev_word_o[25:22]), 34'(VEC[i][3:0]));
        end
        check("R8 reserved", 34'({prev_word_o[27:26], prev_word_o[21:0]}), 34'h0);

        // image 1 path: R2, R3, R4
        do_reset();
        pulse_start(1'b1);
        check("R2 image1", 34'(st()), 34'h4);
        load_fail_i = 1; step(); load_fail_i = 0;
        check("R3 image1 revert", 34'(st()), 34'h5);
        load_fail_i = 1; step(); load_fail_i = 0;
        check("R4 revert fail", 34'(st()), 34'hF);
        check("R10 fail no event", 34'(prev_word_o), 34'h0);

        // R6/R11 expiry timing
        do_reset();
        wd_en_i = 1'b1;
        pulse_start(1'b0);
        check("R5 layout", cur_word_o, {4'b0010, 1'b1, 29'(T)});
        pulse_done();
        for (int i = 0; i < T; i++) step();
        check("R6 before expiry", 34'(st()), 34'h2);
        step();
        check("R6 expiry state", 34'(st()), 34'h3);
        check("R11 wdtimer flag", 34'(prev_word_o), 34'({4'b0001, 2'b00, 4'b0010, 22'd0}));

        // R6 no load-done: no expiry
        do_reset();
        pulse_start(1'b0);
        for (int i = 0; i < 3 * T; i++) step();
        check("R6 no done", 34'(st()), 34'h2);

        // R7 kick reload
        do_reset();
        pulse_start(1'b0);
        pulse_done();
        step(); step();
        wd_kick_i = 1; step(); wd_kick_i = 0;
        for (int i = 0; i < T; i++) step();
        check("R7 kick held off", 34'(st()), 34'h2);
        step();
        check("R7 expiry after kick", 34'(st()), 34'h3);

        // R12 disabled
        do_reset();
        wd_en_i = 1'b0;
        pulse_start(1'b0);
        pulse_done();
        for (int i = 0; i < 3 * T; i++) step();
        check("R12 disabled state", 34'(st()), 34'h2);
        check("R12 disabled prev", 34'(prev_word_o), 34'h0);

        // same-cycle expiry and CRC event on image 1
        do_reset();
        wd_en_i = 1'b1;
        pulse_start(1'b1);
        pulse_done();
        for (int i = 0; i < T; i++) step();
        ev_crc_i = 1; step(); ev_crc_i = 0;
        check("R9 crc over expiry", 34'(prev_word_o), 34'({4'b0100, 2'b00, 4'b0100, 22'd0}));
        check("R11 revert on expiry", 34'(st()), 34'h5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule